// File: doc/BRIEF.md
# Fractional reference clock divider

This block derives a reference clock from one of up to sixteen source inputs. It divides the chosen source by a programmable integer part plus a 9-bit fraction. Everything runs in one synchronous domain: each source is a sampled level, and the divider counts the rising edges of the selected level. The output half-period is the integer count of source rising edges. A 9-bit phase accumulator takes in the fraction once per half-period, and each overflow stretches that half-period by one more edge. The resulting frequency is source / (2 × (DIV + TRIM/512)).

Software reaches the block through a simple memory-mapped port. Reads are combinational and writes take effect at one clock edge. The block has a control word, a set view and a clear view of that word, and a trim word. DIV and TRIM are held as pending values. They move into the running divider only when software raises the switch bit. The block then performs the load at a safe point and clears the bit itself. A change of source select is also applied only at a safe point. A busy flag reads 1 while either kind of change is outstanding, so software polls the busy flag and the switch bit until both read 0. There is no streaming data path, so the port carries no valid/ready handshake and has no back-pressure.

Top module: `frac_refclk_div`

## Requirements
- R1: After the synchronous active-low reset, the control word and trim word read 0, the block is off, and both clock outputs are low.
- R2: The control word sits at byte offset 0x00. Source select is in bits [3:0], busy in bit 8, switch in bit 9, pin enable in bit 12, run enable in bit 15 and DIV in bits [30:16]. The trim word at offset 0x10 holds TRIM in bits [31:23]. All other bits read 0, and an ordinary write replaces every writable field.
- R3: A write at offset 0x04 clears the control bits written as 1, and a write at offset 0x08 sets them. Busy (bit 8) ignores all writes. Software can set the switch bit but cannot clear it.
- R4: With DIV > 0, every half-period lasts DIV or DIV+1 source rising edges. Any 512 consecutive half-periods total exactly 512·DIV + TRIM edges.
- R5: New DIV and TRIM values have no effect until the switch bit is set. The block then loads them at a safe point and clears the switch bit without software action.
- R6: Busy reads 1 while the switch bit is set or while the source select differs from the source in use.
- R7: A load happens at a falling edge of the internal clock, or while that clock is low, and the internal clock is low right after it. In divided mode the load waits for the falling edge.
- R8: A new source select is applied at the next safe point, even without the switch bit. Index 0 is the system clock, index 7 the system PLL output and index 8 the external reference pin.
- R9: With DIV = 0 the internal clock copies the selected source level one clock later, and TRIM has no effect.
- R10: While run enable is 0, the internal clock is low and the fraction accumulator is cleared.
- R11: While pin enable is 0, the pin output is low and the internal clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sources are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr_i | input | 5 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| src_i | input | NSRC | Source levels, one per select index |
| ref_int_o | output | 1 | Internal divided clock |
| ref_o | output | 1 | Output pin clock, gated by pin enable |

## Verification
Four checks are made on every cycle: the internal clock drops whenever run enable is 0; the switch bit clears only at a load and leaves the clock low; and the source in use changes only to the programmed select. The bench's sweeps are needed for the rest. They check the exact edge totals over 512 half-periods for many DIV/TRIM pairs, the bounds on each half-period, and that the old divider keeps running until the switch bit is set. They also cover the bypass copy, the pin gating and the alias arithmetic of the register views.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_CLR  = 5'h04;
  localparam logic [ADDR_W-1:0] A_SET  = 5'h08;
  localparam logic [ADDR_W-1:0] A_TRIM = 5'h10;

  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned ACT_BIT  = 8;
  localparam int unsigned SW_BIT   = 9;
  localparam int unsigned OE_BIT   = 12;
  localparam int unsigned ON_BIT   = 15;
  localparam int unsigned DIV_W    = 15;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned TRIM_W   = 9;
  localparam int unsigned TRIM_LSB = 23;

  typedef struct packed {
    logic             on;
    logic             oe;
    logic             sw;
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/frdiv_regs.sv
module frdiv_regs
  import frdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              active_i,
  input  logic              done_i,
  output logic              on_o,
  output logic              oe_o,
  output logic              sw_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TRIM_W-1:0] trim_o
);
  ctrl_t             ctrl_q;
  logic [TRIM_W-1:0] trim_q;
  logic [DATA_W-1:0] ctrl_img;
  logic [DATA_W-1:0] ctrl_nxt;
  logic              ctrl_we;
  logic              sw_set;
  logic              unused_nxt;

  function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c, logic act);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[ACT_BIT]          = act;
    w[SW_BIT]           = c.sw;
    w[OE_BIT]           = c.oe;
    w[ON_BIT]           = c.on;
    w[DIV_LSB +: DIV_W] = c.div;
    return w;
  endfunction

  always_comb begin
    ctrl_img = pack_ctrl(ctrl_q, 1'b0);
    ctrl_we  = we_i && (addr_i == A_CTRL || addr_i == A_CLR || addr_i == A_SET);
    sw_set   = we_i && (addr_i == A_CTRL || addr_i == A_SET) && wdata_i[SW_BIT];
    case (addr_i)
      A_CLR:   ctrl_nxt = ctrl_img & ~wdata_i;
      A_SET:   ctrl_nxt = ctrl_img | wdata_i;
      default: ctrl_nxt = wdata_i;
    endcase
  end

  assign unused_nxt = ^{ctrl_nxt[DATA_W-1], ctrl_nxt[14:13], ctrl_nxt[11:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trim_q <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl_q.sel <= ctrl_nxt[SEL_LSB +: SEL_W];
        ctrl_q.oe  <= ctrl_nxt[OE_BIT];
        ctrl_q.on  <= ctrl_nxt[ON_BIT];
        ctrl_q.div <= ctrl_nxt[DIV_LSB +: DIV_W];
      end
      ctrl_q.sw <= (ctrl_q.sw & ~done_i) | sw_set;
      if (we_i && addr_i == A_TRIM) begin
        trim_q <= wdata_i[TRIM_LSB +: TRIM_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = pack_ctrl(ctrl_q, active_i);
      A_TRIM:  rdata_o[TRIM_LSB +: TRIM_W] = trim_q;
      default: rdata_o = '0;
    endcase
  end

  assign on_o   = ctrl_q.on;
  assign oe_o   = ctrl_q.oe;
  assign sw_o   = ctrl_q.sw;
  assign sel_o  = ctrl_q.sel;
  assign div_o  = ctrl_q.div;
  assign trim_o = trim_q;
endmodule

// File: rtl/frdiv_srcsel.sv
module frdiv_srcsel
  import frdiv_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_pend_i,
  input  logic             load_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             sel_change_o,
  output logic [SEL_W-1:0] sel_run_o
);
  localparam int unsigned NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0] slot;
  logic [SEL_W-1:0] sel_run;
  logic             prev_q;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < NSRC) begin : g_live
        assign slot[g] = src_i[g];
      end else begin : g_tie
        assign slot[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_run <= '0;
      prev_q  <= 1'b0;
    end else if (load_i) begin
      sel_run <= sel_pend_i;
      prev_q  <= slot[sel_pend_i];
    end else begin
      prev_q  <= slot[sel_run];
    end
  end

  assign lvl_o        = slot[sel_run];
  assign rise_o       = slot[sel_run] & ~prev_q;
  assign sel_change_o = (sel_pend_i != sel_run);
  assign sel_run_o    = sel_run;
endmodule

// File: rtl/frdiv_halfgen.sv
module frdiv_halfgen
  import frdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_i,
  input  logic              sw_i,
  input  logic              sel_change_i,
  input  logic [DIV_W-1:0]  div_pend_i,
  input  logic [TRIM_W-1:0] trim_pend_i,
  input  logic              lvl_i,
  input  logic              rise_i,
  output logic              load_o,
  output logic              done_o,
  output logic              ref_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [DIV_W-1:0]  div_run;
  logic [TRIM_W-1:0] trim_run;
  logic [TRIM_W-1:0] acc;
  logic              stretch;
  logic              out_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_len;
  logic [TRIM_W:0]   acc_sum;
  logic              bypass;
  logic              half_end;
  logic              safe;

  always_comb begin
    bypass   = (div_run == '0);
    half_len = {1'b0, div_run} + CNT_W'(stretch);
    half_end = rise_i && (cnt == half_len - CNT_W'(1));
    acc_sum  = {1'b0, acc} + {1'b0, trim_run};
    safe     = !on_i || (bypass ? !out_q : (out_q && half_end));
    load_o   = safe && (sw_i || sel_change_i);
    done_o   = load_o && sw_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_run  <= '0;
      trim_run <= '0;
      acc      <= '0;
      stretch  <= 1'b0;
      cnt      <= '0;
      out_q    <= 1'b0;
    end else if (load_o) begin
      out_q   <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
      if (sw_i) begin
        div_run  <= div_pend_i;
        trim_run <= trim_pend_i;
      end
    end else if (!on_i) begin
      out_q   <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
    end else if (bypass) begin
      out_q   <= lvl_i;
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
    end else if (rise_i) begin
      if (half_end) begin
        out_q   <= ~out_q;
        cnt     <= '0;
        acc     <= acc_sum[TRIM_W-1:0];
        stretch <= acc_sum[TRIM_W];
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign ref_o = out_q;
endmodule

// File: rtl/frac_refclk_div.sv
module frac_refclk_div
  import frdiv_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              ref_int_o,
  output logic              ref_o
);
  logic              cfg_on;
  logic              cfg_oe;
  logic              cfg_sw;
  logic [SEL_W-1:0]  cfg_sel;
  logic [DIV_W-1:0]  cfg_div;
  logic [TRIM_W-1:0] cfg_trim;
  logic              gen_load;
  logic              gen_done;
  logic              src_lvl;
  logic              src_rise;
  logic              sel_change;
  logic [SEL_W-1:0]  sel_run;
  logic              busy;

  assign busy = cfg_sw | sel_change;

  frdiv_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .active_i (busy),
    .done_i   (gen_done),
    .on_o     (cfg_on),
    .oe_o     (cfg_oe),
    .sw_o     (cfg_sw),
    .sel_o    (cfg_sel),
    .div_o    (cfg_div),
    .trim_o   (cfg_trim)
  );

  frdiv_srcsel #(.NSRC(NSRC)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .sel_pend_i   (cfg_sel),
    .load_i       (gen_load),
    .lvl_o        (src_lvl),
    .rise_o       (src_rise),
    .sel_change_o (sel_change),
    .sel_run_o    (sel_run)
  );

  frdiv_halfgen u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .on_i         (cfg_on),
    .sw_i         (cfg_sw),
    .sel_change_i (sel_change),
    .div_pend_i   (cfg_div),
    .trim_pend_i  (cfg_trim),
    .lvl_i        (src_lvl),
    .rise_i       (src_rise),
    .load_o       (gen_load),
    .done_o       (gen_done),
    .ref_o        (ref_int_o)
  );

  assign ref_o = ref_int_o & cfg_oe;
endmodule

// File: rtl/frdiv_chk.sv
module frdiv_chk
  import frdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             on,
  input logic             sw,
  input logic             load,
  input logic             ref_int,
  input logic [SEL_W-1:0] sel_pend,
  input logic [SEL_W-1:0] sel_run
);
  a_r10_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !ref_int);

  a_r7_load_leaves_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw) |-> !ref_int);

  a_r3_switch_cleared_by_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw) |-> $past(load));

  a_r8_source_from_select: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_run) |-> (sel_run == $past(sel_pend)));
endmodule

bind frac_refclk_div frdiv_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .on       (cfg_on),
  .sw       (cfg_sw),
  .load     (gen_load),
  .ref_int  (ref_int_o),
  .sel_pend (cfg_sel),
  .sel_run  (sel_run)
);

// File: tb/frac_refclk_div_tb.sv
module frac_refclk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [4:0]  O_CTRL = 5'h00, O_CLR = 5'h04, O_SET = 5'h08, O_TRIM = 5'h10;
  localparam logic [31:0] B_ON = 32'h0000_8000, B_OE = 32'h0000_1000, B_SW = 32'h0000_0200;
  localparam logic [31:0] M_DIV = 32'h7FFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] src;
  logic        ref_int, ref_pin;
  logic        sys_q = 1'b0, pll_q = 1'b0;
  logic [1:0]  pll_div = '0;
  logic [7:0]  lfsr = 8'h5A;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    sys_q   <= ~sys_q;
    pll_div <= pll_div + 2'd1;
    if (pll_div[0]) pll_q <= ~pll_q;
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  assign src = {7'b0, lfsr[0], pll_q, 6'b0, sys_q};

  frac_refclk_div #(.NSRC(16)) u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr_i (addr), .bus_we_i (we),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .src_i (src),
    .ref_int_o (ref_int), .ref_o (ref_pin)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(O_CTRL, d);
      if (d[9] == 1'b0 && d[8] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    logic last;
    do begin
      last = ref_pin;
      @(negedge clk);
    end while (!(ref_pin && !last));
  endtask

  task automatic measure(input int per, input int div, input int trim, input string tag);
    logic last;
    int   len, sum;
    bit   ok;
    wait_rise();
    sum = 0; ok = 1;
    for (int h = 0; h < 512; h++) begin
      len = 0; last = ref_pin;
      do begin
        @(negedge clk);
        len++;
      end while (ref_pin == last);
      if (len != per*div && len != per*(div+1)) ok = 0;
      sum += len;
    end
    chk(ok, {tag, " half-period bounds"}, len, per*div);
    chk(sum == per*(512*div + trim), {tag, " total over 512 halves"}, sum, per*(512*div + trim));
  endtask

  task automatic post_load_low(input string tag);
    wait_idle();
    chk(ref_pin == 1'b0, {tag, " low after load"}, ref_pin, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    summary();
  end

  initial begin
    logic [31:0] d;
    int divs[7]  = '{1, 1, 1,   2, 2,   3, 3};
    int trims[7] = '{0, 1, 511, 0, 256, 100, 511};
    bit ok;
    int moves;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd(O_CTRL, d); chk(d == 0, "R1 control after reset", d, 0);
    rd(O_TRIM, d); chk(d == 0, "R1 trim after reset", d, 0);
    chk(ref_int == 0 && ref_pin == 0, "R1 outputs after reset", {ref_int, ref_pin}, 0);

    // R2 / R6 / R8: plain write, busy until the source commits
    wr(O_CTRL, 32'h7FFF_F00F);
    rd(O_CTRL, d); chk(d == 32'h7FFF_910F, "R6 busy on source change", d, 32'h7FFF_910F);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 32'h7FFF_900F, "R2 readback after source applied", d, 32'h7FFF_900F);
    // R3: clear and set views
    wr(O_CLR, 32'h0000_8003);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 32'h7FFF_100C, "R3 clear view", d, 32'h7FFF_100C);
    wr(O_SET, 32'h0000_0003);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 32'h7FFF_100F, "R3 set view", d, 32'h7FFF_100F);
    wr(O_SET, 32'h0000_0100);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 32'h7FFF_100F, "R3 busy bit not writable", d, 32'h7FFF_100F);
    wr(O_CLR, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 0, "R3 clear all", d, 0);
    wr(O_TRIM, 32'hFFFF_FFFF);
    rd(O_TRIM, d); chk(d == 32'hFF80_0000, "R2 trim field", d, 32'hFF80_0000);
    // R5: switch while off loads at once and self-clears
    wr(O_CTRL, 32'h0002_0200);
    rd(O_CTRL, d); chk(d == 32'h0002_0300, "R5 switch pending", d, 32'h0002_0300);
    @(negedge clk);
    rd(O_CTRL, d); chk(d == 32'h0002_0000, "R5 switch self-clears", d, 32'h0002_0000);

    // R4: sweep of divider settings on the system clock (rise every 2 cycles)
    wr(O_TRIM, 32'(trims[0]) << 23);
    wr(O_CTRL, (32'(divs[0]) << 16) | B_ON | B_OE | B_SW);
    post_load_low("R7 first load");
    measure(2, divs[0], trims[0], "R4 div=1 trim=0");
    for (int i = 1; i < 7; i++) begin
      wr(O_TRIM, 32'(trims[i]) << 23);
      wr(O_CLR, M_DIV);
      wr(O_SET, (32'(divs[i]) << 16) | B_SW);
      post_load_low("R7 sweep load");
      measure(2, divs[i], trims[i], $sformatf("R4 div=%0d trim=%0d", divs[i], trims[i]));
    end

    // R5: pending values without switch leave the running divider alone
    wr(O_TRIM, 32'd5 << 23);
    wr(O_CLR, M_DIV);
    wr(O_SET, 32'h0001_0000);
    measure(2, 3, 511, "R5 old divider kept");
    // R3: software cannot clear the switch bit
    wait_rise();
    wr(O_SET, B_SW);
    wr(O_CLR, B_SW);
    rd(O_CTRL, d); chk(d[9] == 1'b1, "R3 switch survives clear view", d[9], 1);
    post_load_low("R7 divided load");
    measure(2, 1, 5, "R5 new divider after switch");

    // R11: pin gating
    wr(O_CLR, B_OE);
    ok = 1; moves = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ref_pin) ok = 0;
      if (ref_int != (i % 2 == 0 ? ref_int : ref_int)) moves = moves;
      if (i > 0 && ref_int) moves++;
    end
    chk(ok, "R11 pin low while disabled", ref_pin, 0);
    chk(moves > 0, "R11 internal clock keeps running", moves, 1);
    wr(O_SET, B_OE);

    // R10: run enable off
    wr(O_CLR, B_ON);
    @(negedge clk);
    ok = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ref_int) ok = 0;
    end
    chk(ok, "R10 internal clock low while off", ref_int, 0);
    wr(O_SET, B_ON);
    measure(2, 1, 5, "R10 resumes after off");

    // R8 / R6: move to the PLL source (index 7, rise every 4 cycles)
    wr(O_TRIM, 32'd0);
    wr(O_SET, 32'h0000_0007 | B_SW);
    rd(O_CTRL, d); chk(d[8] == 1'b1, "R6 busy during source change", d[8], 1);
    post_load_low("R7 source load");
    measure(4, 1, 0, "R8 PLL source index 7");

    // R9: bypass of the external pin source (index 8), trim ignored
    wr(O_TRIM, 32'd300 << 23);
    wr(O_CLR, M_DIV | 32'h0000_000F);
    wr(O_SET, 32'h0000_0008 | B_SW);
    wait_idle();
    ok = 1;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk);
      #1;
      if (ref_int != src[8] || ref_pin != src[8]) ok = 0;
    end
    chk(ok, "R9 bypass copies source", ref_int, src[8]);

    summary();
  end
endmodule